// File: doc/BRIEF.md
# Wavefront Issue Scheduler with Register-Read Arbitration

This block is the issue stage of a GPU-style compute unit. It owns one dispatch slot per vector execution unit and one per memory pipe, and the memory-pipe slots are numbered after all the execution slots. In every cycle, each slot takes the set of wavefronts that are ready for it and grants one of them with a round-robin pointer. The grant lands in a registered dispatch entry that holds a valid bit, the wave id and the SIMD id.

Once every slot has made its pick, the block runs an arbitration pass. A memory-pipe pick takes precedence over any execution pick that sits on the same SIMD and needs an overlapping set of vector register read banks. The losing execution pick is withdrawn, its slot is left empty, and its wave stays ready. Memory picks are never compared with each other. Write-port conflicts are not checked, because a later stage resolves them. The per-wave status output marks as blocked every wave whose grant survived arbitration.

Top module: `wave_issue_sched`

## Requirements
- R1: Slots 0 to N_SIMD-1 are execution slots and the slots above them are memory-pipe slots. Wave w belongs to SIMD w / WAVES_PER_SIMD, and a granted slot reports that SIMD on `disp_simd_o`. An empty slot reports SIMD 0.
- R2: A slot whose ready mask (`ready_i[s*N_WAVE +: N_WAVE]`) is zero shows valid=0 and wave id 0 one cycle later.
- R3: A slot whose ready mask is non-zero, and whose pick is not withdrawn, shows valid=1 one cycle later. The wave id it shows is a wave that was set in that mask.
- R4: One cycle after the picks, `wave_busy_o[w]` is 1 (BLOCKED) exactly for the waves that were granted and kept. Every other wave reads 0 (READY), and this includes waves whose pick was withdrawn.
- R5: An execution pick is withdrawn when any memory-pipe pick is on the same SIMD and their read-bank masks (`banks_i[w*BANKS +: BANKS]`) share a set bit. This holds even when several memory picks conflict with it at once.
- R6: A memory-pipe pick is never withdrawn. Two memory picks on the same SIMD with overlapping banks both stay valid.
- R7: Two execution picks on the same SIMD with overlapping banks both stay valid.
- R8: Each slot grants the first ready wave at or after its pointer, wrapping round the wave count. The pointer moves to one past the granted wave only when the grant is kept. A withdrawn pick leaves the pointer where it was.
- R9: A synchronous active-high reset clears every dispatch entry, every busy bit and every pointer. The first pick after reset searches from wave 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | N_SLOT*N_WAVE | Per-slot ready mask over all waves |
| banks_i | input | N_WAVE*BANKS | Per-wave register read-bank mask |
| disp_valid_o | output | N_SLOT | Slot holds a dispatched wave |
| disp_wave_o | output | N_SLOT*WW | Dispatched wave id per slot |
| disp_simd_o | output | N_SLOT*SW | SIMD of the dispatched wave per slot |
| wave_busy_o | output | N_WAVE | 1 = BLOCKED, 0 = READY, per wave |

## Verification
Each result appears exactly one register stage after its inputs: a ready mask and bank masks driven before edge n show up on the dispatch and busy outputs just after edge n. Pointer effects show up at the next vector after that. The bench drives on the falling edge, lets one rising edge pass, and samples on the following falling edge. It walks a vector chain in which each expected pick is worked out from the pointer positions that the earlier vectors leave behind.

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int N_SIMD         = 2,
  parameter int N_MEM          = 2,
  parameter int WAVES_PER_SIMD = 4,
  parameter int BANKS          = 4,
  localparam int N_SLOT = N_SIMD + N_MEM,
  localparam int N_WAVE = N_SIMD * WAVES_PER_SIMD,
  localparam int WW     = (N_WAVE > 1) ? $clog2(N_WAVE) : 1,
  localparam int SW     = (N_SIMD > 1) ? $clog2(N_SIMD) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SLOT*N_WAVE-1:0] ready_i,
  input  logic [N_WAVE*BANKS-1:0]  banks_i,
  output logic [N_SLOT-1:0]        disp_valid_o,
  output logic [N_SLOT*WW-1:0]     disp_wave_o,
  output logic [N_SLOT*SW-1:0]     disp_simd_o,
  output logic [N_WAVE-1:0]        wave_busy_o
);

  function automatic int simd_of(input logic [WW-1:0] w);
    return int'(w) / WAVES_PER_SIMD;
  endfunction

  function automatic logic [BANKS-1:0] bank_of(input logic [WW-1:0] w);
    return banks_i[int'(w)*BANKS +: BANKS];
  endfunction

  logic [WW-1:0]     ptr_q [N_SLOT];
  logic [WW-1:0]     pick  [N_SLOT];
  logic [N_SLOT-1:0] hit, kill, grant;
  logic [N_WAVE-1:0] busy_n;

  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      hit[s]  = 1'b0;
      pick[s] = '0;
      for (int k = 0; k < N_WAVE; k++) begin
        if (!hit[s] && ready_i[s*N_WAVE + (int'(ptr_q[s]) + k) % N_WAVE]) begin
          hit[s]  = 1'b1;
          pick[s] = WW'((int'(ptr_q[s]) + k) % N_WAVE);
        end
      end
    end
  end

  always_comb begin
    kill = '0;
    for (int i = 0; i < N_SIMD; i++)
      for (int j = N_SIMD; j < N_SLOT; j++)
        if (hit[i] && hit[j] && simd_of(pick[i]) == simd_of(pick[j]) &&
            (bank_of(pick[i]) & bank_of(pick[j])) != '0)
          kill[i] = 1'b1;
  end

  assign grant = hit & ~kill;

  always_comb begin
    busy_n = '0;
    for (int w = 0; w < N_WAVE; w++)
      for (int s = 0; s < N_SLOT; s++)
        if (grant[s] && pick[s] == WW'(w)) busy_n[w] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid_o <= '0;
      disp_wave_o  <= '0;
      disp_simd_o  <= '0;
      wave_busy_o  <= '0;
      for (int s = 0; s < N_SLOT; s++) ptr_q[s] <= '0;
    end else begin
      disp_valid_o <= grant;
      wave_busy_o  <= busy_n;
      for (int s = 0; s < N_SLOT; s++) begin
        disp_wave_o[s*WW +: WW] <= grant[s] ? pick[s] : '0;
        disp_simd_o[s*SW +: SW] <= grant[s] ? SW'(simd_of(pick[s])) : '0;
        if (grant[s]) ptr_q[s] <= WW'((int'(pick[s]) + 1) % N_WAVE);
      end
    end
  end

  p_busy_le_valid_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(wave_busy_o) <= $countones(disp_valid_o));

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot_chk
    p_empty_idle_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(ready_i[s*N_WAVE +: N_WAVE]) == '0) |-> !disp_valid_o[s]);
    p_pick_was_ready_r3: assert property (@(posedge clk) disable iff (rst)
      disp_valid_o[s] |->
        (($past(ready_i[s*N_WAVE +: N_WAVE]) >> disp_wave_o[s*WW +: WW]) & N_WAVE'(1)) != '0);
    if (s >= N_SIMD) begin : g_mem
      p_mem_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ready_i[s*N_WAVE +: N_WAVE]) != '0) |-> disp_valid_o[s]);
    end
  end

  for (genvar i = 0; i < N_SIMD; i++) begin : g_exe_chk
    for (genvar j = N_SIMD; j < N_SLOT; j++) begin : g_mem_pair
      p_mem_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_valid_o[i] && disp_valid_o[j] &&
         disp_simd_o[i*SW +: SW] == disp_simd_o[j*SW +: SW]) |->
        ((BANKS'($past(banks_i) >> (BANKS*int'(disp_wave_o[i*WW +: WW]))) &
          BANKS'($past(banks_i) >> (BANKS*int'(disp_wave_o[j*WW +: WW])))) == '0));
    end
  end

endmodule

// File: tb/test_wave_issue_sched.sv
module test_wave_issue_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ready_i = '0;
  logic [31:0] banks_i = 32'h8421_8421;
  logic [3:0]  disp_valid_o;
  logic [11:0] disp_wave_o;
  logic [3:0]  disp_simd_o;
  logic [7:0]  wave_busy_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wave_issue_sched i_wave_issue_sched (
    .clk(clk), .rst(rst), .ready_i(ready_i), .banks_i(banks_i),
    .disp_valid_o(disp_valid_o), .disp_wave_o(disp_wave_o),
    .disp_simd_o(disp_simd_o), .wave_busy_o(wave_busy_o));

  // {ready, banks, valid, wave ids s3..s0, simd s3..s0, busy}
  localparam logic [91:0] VEC [8] = '{
    {32'h0000_0000, 32'h8421_8421, 4'b0000, 12'h000, 4'b0000, 8'h00},
    {32'h0000_2002, 32'h8421_8421, 4'b0011, 12'h029, 4'b0010, 8'h22},
    {32'h4010_0009, 32'h8421_8421, 4'b1101, 12'hD03, 4'b1100, 8'h58},
    {32'h0004_8001, 32'h8421_8223, 4'b0110, 12'h0B8, 4'b0010, 8'h84},
    {32'h0000_0022, 32'h8421_8421, 4'b0001, 12'h005, 4'b0001, 8'h20},
    {32'h0401_1002, 32'h842F_8F1F, 4'b1110, 12'h420, 4'b0010, 8'h15},
    {32'h0000_0804, 32'h8421_FF21, 4'b0011, 12'h01A, 4'b0000, 8'h0C},
    {32'h0008_0002, 32'h8421_8421, 4'b0101, 12'h0C1, 4'b0000, 8'h0A}
  };
  string vtag [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    vtag[0] = "R2 empty masks";
    vtag[1] = "R3 single picks";
    vtag[2] = "R8 pointer skip";
    vtag[3] = "R5 mem beats exec";
    vtag[4] = "R8 pointer held after cancel";
    vtag[5] = "R6 mem pair overlap, R5 double conflict";
    vtag[6] = "R7 exec pair overlap";
    vtag[7] = "R1 same SIMD disjoint banks";

    @(negedge clk); @(negedge clk);
    chk("R9 reset valid", 32'(disp_valid_o), 0);
    chk("R9 reset busy", 32'(wave_busy_o), 0);
    rst = 1'b0;

    foreach (VEC[v]) begin
      ready_i = VEC[v][91:60];
      banks_i = VEC[v][59:28];
      @(negedge clk);
      chk({vtag[v], " valid"}, 32'(disp_valid_o), 32'(VEC[v][27:24]));
      chk({vtag[v], " wave"},  32'(disp_wave_o),  32'(VEC[v][23:12]));
      chk({"R1 ", vtag[v], " simd"}, 32'(disp_simd_o), 32'(VEC[v][11:8]));
      chk({"R4 ", vtag[v], " busy"}, 32'(wave_busy_o), 32'(VEC[v][7:0]));
    end

    // R9: reset mid-run clears outputs and pointers
    ready_i = 32'h0000_0022;
    banks_i = 32'h8421_8421;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 midrun valid", 32'(disp_valid_o), 0);
    chk("R9 midrun wave", 32'(disp_wave_o), 0);
    chk("R9 midrun busy", 32'(wave_busy_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 pointer from zero", 32'(disp_wave_o), 32'h001);
    chk("R4 busy after reset", 32'(wave_busy_o), 32'h02);

    // R2: mask goes empty again
    ready_i = '0;
    @(negedge clk);
    chk("R2 empty after pick", 32'(disp_valid_o), 0);
    chk("R4 all ready", 32'(wave_busy_o), 0);

    finish_run();
  end
endmodule